// File: doc/BRIEF.md
# Watchdog Timer with Selectable Interrupt or Reset Action

The block is a supervisory timer. Software must restart it periodically. It counts ticks from one of four clock-source tick inputs through a prescaler. The divide ratio depends on both the selected source and a 2-bit divider code. When the count reaches the timeout without a restart, the block takes the configured action. In NMI mode it raises a sticky non-maskable interrupt flag. In reset mode it emits a fixed-length system reset pulse.

Software controls the timer through two 16-bit registers. The clock-configuration register holds the source select, the divider code and the debug-run enable. The control register holds the 4-bit run code, the restart strobe, the mode select and the NMI status. Writes are accepted only while the protection-open input is high.

A debug-mode input can freeze counting unless the debug-run bit is set. The source ticks are modelled as single-cycle enables in the system clock domain.

Top module: `wd_nmi_top`

## Requirements
- R1: After reset the configuration register reads 0x0000 and the control register reads 0x000A (run code 0xA, reset mode). `nmi_o` and `rst_o` are low.
- R2: A register write while `prot_open` is low leaves every stored field unchanged and issues no restart.
- R3: Field layout:
  - Configuration register (address 0): debug-run at bit 0, divider code at bits 3:2, source at bits 5:4.
  - Control register (address 1): run code at bits 3:0, restart at bit 7, mode at bit 10 (1 = NMI, 0 = reset), NMI status at bit 15.
  - All other bits read 0, and the restart bit always reads 0.
- R4: A source code whose bit in `SRC_PRESENT` is clear is not accepted. The previous source is kept, while the other fields of the same write still take effect.
- R5: For sources 0 and 2 the prescale ratio is 2^(DIV_BASE_LOG2 + divider code).
- R6: Source 1 uses a fixed ratio of 2^LOW_LOG2 and source 3 uses ratio 1. For both, the divider code is ignored.
- R7: Run code 0xA stops the counter and prescaler, which hold their values. Any other run code lets them count.
- R8: While `dbg_i` is high and debug-run is 0, counting freezes. With debug-run set to 1, `dbg_i` has no effect.
- R9: A timeout occurs on the TIMEOUT_TICKS-th counter tick after a restart. It becomes visible at the outputs right after that clock edge.
- R10: In reset mode each timeout drives `rst_o` high for exactly RST_PULSE cycles, and `nmi_o` stays low.
- R11: In NMI mode a timeout sets the status bit, which drives `nmi_o`. It stays set until a restart.
- R12: A restart clears the counter, the prescaler and the NMI status on the same edge as the write. A restart wins over a timeout that would fall on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | 4 | One-cycle tick enables, one per clock source |
| dbg_i | input | 1 | Debug-mode indication |
| prot_open | input | 1 | High allows register writes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects configuration, 1 selects control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| nmi_o | output | 1 | Non-maskable interrupt request (status level) |
| rst_o | output | 1 | System reset request pulse |

## Verification
A software restart and the terminal counter tick can land on the same clock edge. This is the case the bench targets directly. With the ratio-1 source ticking every cycle, the bench issues a second restart write exactly TIMEOUT_TICKS cycles after the first. It then expects no NMI at that edge and a new full timeout period measured from the second write. Divide ratios are swept across every present source and divider code, and each measured timeout is compared against ratio × TIMEOUT_TICKS computed in the bench.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam logic [3:0] RUN_STOP = 4'hA;

  localparam int CC_DBG  = 0;
  localparam int CC_DIV  = 2;
  localparam int CC_SRC  = 4;
  localparam int CT_REST = 7;
  localparam int CT_MODE = 10;
  localparam int CT_STAT = 15;

  typedef enum logic [1:0] {
    SRC_HFA = 2'd0,
    SRC_LF  = 2'd1,
    SRC_HFB = 2'd2,
    SRC_EXT = 2'd3
  } src_e;

  typedef struct packed {
    logic       dbg_run;
    logic [1:0] div;
    src_e       src;
  } clkcfg_t;
endpackage

// File: rtl/wd_regs.sv
module wd_regs
  import wd_pkg::*;
#(
  parameter logic [3:0] SRC_PRESENT = 4'b1111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        addr,
  input  logic [15:0] wdata,
  input  logic        prot_open,
  input  logic        nmi_stat,
  output clkcfg_t     cfg,
  output logic [3:0]  run_code,
  output logic        mode_nmi,
  output logic        restart,
  output logic [15:0] rdata
);
  clkcfg_t    cfg_d;
  logic [3:0] run_d;
  logic       mode_d;
  logic       wr_ok;
  logic       unused_bits;

  assign wr_ok       = we && prot_open;
  assign unused_bits = ^{wdata[15:11], wdata[9:8], wdata[6:6], wdata[1]};

  always_comb begin
    cfg_d   = cfg;
    run_d   = run_code;
    mode_d  = mode_nmi;
    restart = 1'b0;
    if (wr_ok) begin
      if (!addr) begin
        cfg_d.dbg_run = wdata[CC_DBG];
        cfg_d.div     = wdata[CC_DIV+1:CC_DIV];
        if (SRC_PRESENT[wdata[CC_SRC+1:CC_SRC]])
          cfg_d.src = src_e'(wdata[CC_SRC+1:CC_SRC]);
      end else begin
        run_d   = wdata[3:0];
        mode_d  = wdata[CT_MODE];
        restart = wdata[CT_REST];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '{dbg_run: 1'b0, div: 2'd0, src: SRC_HFA};
      run_code <= RUN_STOP;
      mode_nmi <= 1'b0;
    end else begin
      cfg      <= cfg_d;
      run_code <= run_d;
      mode_nmi <= mode_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (!addr) begin
      rdata[CC_DBG]           = cfg.dbg_run;
      rdata[CC_DIV+1:CC_DIV]  = cfg.div;
      rdata[CC_SRC+1:CC_SRC]  = cfg.src;
    end else begin
      rdata[3:0]     = run_code;
      rdata[CT_MODE] = mode_nmi;
      rdata[CT_STAT] = nmi_stat;
    end
  end
endmodule

// File: rtl/wd_prescale.sv
module wd_prescale
  import wd_pkg::*;
#(
  parameter int DIV_BASE_LOG2 = 13,
  parameter int LOW_LOG2      = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] src_tick,
  input  src_e       src,
  input  logic [1:0] div,
  input  logic       enable,
  input  logic       clear,
  output logic       ctick
);
  localparam int HI_W  = DIV_BASE_LOG2 + 3;
  localparam int PRE_W = (HI_W > LOW_LOG2) ? HI_W : ((LOW_LOG2 > 0) ? LOW_LOG2 : 1);

  logic [PRE_W-1:0] pre_q, pre_d, term;
  logic [PRE_W:0]   span;
  logic [7:0]       shamt;
  logic             step;

  always_comb begin
    case (src)
      SRC_LF:  shamt = 8'(LOW_LOG2);
      SRC_EXT: shamt = 8'd0;
      default: shamt = 8'(DIV_BASE_LOG2) + {6'd0, div};
    endcase
    span = ({{PRE_W{1'b0}}, 1'b1} << shamt) - 1'b1;
    term = span[PRE_W-1:0];
  end

  assign step  = enable && src_tick[src];
  assign ctick = step && !clear && (pre_q >= term);

  always_comb begin
    pre_d = pre_q;
    if (clear)      pre_d = '0;
    else if (ctick) pre_d = '0;
    else if (step)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wd_counter.sv
module wd_counter #(
  parameter int TIMEOUT_TICKS = 128,
  parameter int RST_PULSE     = 4,
  localparam int CW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1,
  localparam int RW = $clog2(RST_PULSE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctick,
  input  logic          clear,
  input  logic          mode_nmi,
  output logic [CW-1:0] count,
  output logic          nmi_stat,
  output logic          rst_out
);
  logic [CW-1:0] cnt_d;
  logic [RW-1:0] pulse_q, pulse_d;
  logic          stat_d;
  logic          last, expire;

  assign last   = (count == CW'(TIMEOUT_TICKS - 1));
  assign expire = ctick && !clear && last;

  always_comb begin
    cnt_d = count;
    if (clear)      cnt_d = '0;
    else if (ctick) cnt_d = last ? '0 : count + 1'b1;

    stat_d = nmi_stat;
    if (clear)                    stat_d = 1'b0;
    else if (expire && mode_nmi)  stat_d = 1'b1;

    pulse_d = pulse_q;
    if (expire && !mode_nmi)      pulse_d = RW'(RST_PULSE);
    else if (pulse_q != '0)       pulse_d = pulse_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      nmi_stat <= 1'b0;
      pulse_q  <= '0;
    end else begin
      count    <= cnt_d;
      nmi_stat <= stat_d;
      pulse_q  <= pulse_d;
    end
  end

  assign rst_out = (pulse_q != '0);
endmodule

// File: rtl/wd_nmi_top.sv
module wd_nmi_top
  import wd_pkg::*;
#(
  parameter int         DIV_BASE_LOG2 = 13,
  parameter int         LOW_LOG2      = 7,
  parameter int         TIMEOUT_TICKS = 128,
  parameter int         RST_PULSE     = 4,
  parameter logic [3:0] SRC_PRESENT   = 4'b1111,
  localparam int CW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  src_tick,
  input  logic        dbg_i,
  input  logic        prot_open,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        nmi_o,
  output logic        rst_o
);
  logic [1:0]    rs_q;
  logic          srst_n;
  clkcfg_t       cfg;
  logic [3:0]    run_code;
  logic          mode_nmi, restart, nmi_stat, count_en, ctick;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  assign count_en = (run_code != RUN_STOP) && !(dbg_i && !cfg.dbg_run);

  wd_regs #(.SRC_PRESENT(SRC_PRESENT)) u_regs (
    .clk(clk), .rst_n(srst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .prot_open(prot_open), .nmi_stat(nmi_stat), .cfg(cfg), .run_code(run_code),
    .mode_nmi(mode_nmi), .restart(restart), .rdata(reg_rdata)
  );

  wd_prescale #(.DIV_BASE_LOG2(DIV_BASE_LOG2), .LOW_LOG2(LOW_LOG2)) u_pre (
    .clk(clk), .rst_n(srst_n), .src_tick(src_tick), .src(cfg.src), .div(cfg.div),
    .enable(count_en), .clear(restart), .ctick(ctick)
  );

  wd_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS), .RST_PULSE(RST_PULSE)) u_cnt (
    .clk(clk), .rst_n(srst_n), .ctick(ctick), .clear(restart), .mode_nmi(mode_nmi),
    .count(count), .nmi_stat(nmi_stat), .rst_out(rst_o)
  );

  assign nmi_o = nmi_stat;
endmodule

// File: rtl/wd_nmi_chk.sv
module wd_nmi_chk
  import wd_pkg::*;
#(
  parameter int RST_PULSE = 4,
  parameter int CW        = 7
) (
  input logic          clk,
  input logic          srst_n,
  input logic          reg_we,
  input logic          reg_addr,
  input logic          prot_open,
  input logic [15:0]   reg_rdata,
  input clkcfg_t       cfg,
  input logic [3:0]    run_code,
  input logic          mode_nmi,
  input logic          restart,
  input logic          dbg_i,
  input logic [CW-1:0] count,
  input logic          nmi_o,
  input logic          rst_o
);
  localparam int LW = $clog2(RST_PULSE + 2);
  logic [LW-1:0] hi_len;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    hi_len <= '0;
    else if (rst_o) hi_len <= hi_len + 1'b1;
    else            hi_len <= '0;
  end

  AST_PROT_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !(reg_we && prot_open) |=> ($stable(cfg) && $stable(run_code) && $stable(mode_nmi))); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_addr ? (reg_rdata & 16'h7BF0) : (reg_rdata & 16'hFFC2)) == 16'h0000); // R3
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!srst_n)
    (run_code == RUN_STOP && !restart) |=> $stable(count)); // R7
  AST_DEBUG_FREEZE: assert property (@(posedge clk) disable iff (!srst_n)
    (dbg_i && !cfg.dbg_run && !restart) |=> $stable(count)); // R8
  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (!srst_n)
    rst_o |-> (hi_len < LW'(RST_PULSE))); // R10
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(rst_o) |-> (hi_len == LW'(RST_PULSE))); // R10
  AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    (nmi_o && !restart) |=> nmi_o); // R11
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    restart |=> (count == '0 && !nmi_o)); // R12
endmodule

bind wd_nmi_top wd_nmi_chk #(.RST_PULSE(RST_PULSE), .CW(CW)) u_chk (
  .clk(clk), .srst_n(srst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .prot_open(prot_open), .reg_rdata(reg_rdata), .cfg(cfg), .run_code(run_code),
  .mode_nmi(mode_nmi), .restart(restart), .dbg_i(dbg_i), .count(count),
  .nmi_o(nmi_o), .rst_o(rst_o)
);

// File: tb/sim_wd_nmi_top.sv
module sim_wd_nmi_top;
  localparam int BASE = 2;
  localparam int LOWL = 3;
  localparam int TMO  = 8;
  localparam int PUL  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  src_tick;
  logic        dbg_i, prot_open, reg_we, reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        nmi_o, rst_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  wd_nmi_top #(.DIV_BASE_LOG2(BASE), .LOW_LOG2(LOWL), .TIMEOUT_TICKS(TMO),
               .RST_PULSE(PUL), .SRC_PRESENT(4'b1011)) u0 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .dbg_i(dbg_i),
    .prot_open(prot_open), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_o(nmi_o), .rst_o(rst_o)
  );

  function automatic logic [15:0] cc_word(input bit dbg, input int dv, input int sr);
    return 16'((sr & 3) << 4) | 16'((dv & 3) << 2) | 16'(dbg);
  endfunction

  function automatic logic [15:0] ct_word(input bit nmi, input bit rs, input logic [3:0] run);
    return (16'(nmi) << 10) | (16'(rs) << 7) | 16'(run);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input bit a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_evt(input bit want_nmi, output int n);
    n = 0;
    while (n < 4000) begin
      @(negedge clk);
      n++;
      if (want_nmi ? nmi_o : rst_o) break;
    end
  endtask

  function automatic int ratio(input int sr, input int dv);
    if (sr == 1) return 1 << LOWL;
    if (sr == 3) return 1;
    return 1 << (BASE + dv);
  endfunction

  initial begin
    logic [15:0] rv;
    int n;
    rst_n = 1'b0; src_tick = 4'hF; dbg_i = 1'b0; prot_open = 1'b1;
    reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(1'b0, rv); check("R1 cfg reset", rv, 16'h0000);
    rd(1'b1, rv); check("R1 ctl reset", rv, 16'h000A);
    check("R1 nmi reset", nmi_o, 0);
    check("R1 rst reset", rst_o, 0);

    // R5 R6 sweep over present sources and all divider codes
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      for (int dv = 0; dv < 4; dv++) begin
        wr(1'b0, cc_word(1'b0, dv, s));
        wr(1'b1, ct_word(1'b1, 1'b1, 4'h0));
        wait_evt(1'b1, n);
        check($sformatf("R5/R6/R9 src%0d div%0d timeout", s, dv), n, ratio(s, dv) * TMO);
      end
    end
    rd(1'b1, rv); check("R11 status bit set", rv[15], 1);
    repeat (20) @(negedge clk);
    check("R11 nmi stays high", nmi_o, 1);
    wr(1'b1, ct_word(1'b1, 1'b1, 4'h0));
    check("R12 restart clears nmi", nmi_o, 0);

    // R4 absent source keeps previous
    wr(1'b0, cc_word(1'b0, 1, 3));
    wr(1'b0, cc_word(1'b1, 2, 2));
    rd(1'b0, rv); check("R4 absent source rejected", rv, cc_word(1'b1, 2, 3));

    // R12 restart on the terminal edge
    wr(1'b0, cc_word(1'b0, 0, 3));
    wr(1'b1, ct_word(1'b1, 1'b1, 4'h5));
    repeat (TMO - 1) @(negedge clk);
    wr(1'b1, ct_word(1'b1, 1'b1, 4'h5));
    check("R12 restart beats timeout", nmi_o, 0);
    wait_evt(1'b1, n);
    check("R12 full period after restart", n, TMO);

    // R8 debug freeze with debug-run 0
    wr(1'b1, ct_word(1'b1, 1'b1, 4'h0));
    n = 0;
    while (n < 200 && !nmi_o) begin
      @(negedge clk); n++;
      if (n == 3) dbg_i = 1'b1;
      if (n == 8) dbg_i = 1'b0;
    end
    check("R8 debug freezes count", n, TMO + 5);
    wr(1'b0, cc_word(1'b1, 0, 3));
    wr(1'b1, ct_word(1'b1, 1'b1, 4'h0));
    dbg_i = 1'b1;
    wait_evt(1'b1, n);
    dbg_i = 1'b0;
    check("R8 debug-run keeps counting", n, TMO);

    // R7 stop code holds
    wr(1'b1, ct_word(1'b1, 1'b1, 4'hA));
    repeat (3 * TMO) @(negedge clk);
    check("R7 stopped no nmi", nmi_o, 0);
    wr(1'b1, ct_word(1'b1, 1'b0, 4'h3));
    wait_evt(1'b1, n);
    check("R7 resume after stop", n, TMO);

    // R10 reset mode pulse
    wr(1'b1, ct_word(1'b0, 1'b1, 4'h0));
    wait_evt(1'b0, n);
    check("R10 reset timeout", n, TMO);
    n = 0;
    while (rst_o && n < 50) begin
      n++; @(negedge clk);
    end
    check("R10 pulse width", n, PUL);
    check("R10 nmi low in reset mode", nmi_o, 0);

    // R2 protection
    wr(1'b1, ct_word(1'b1, 1'b1, 4'hA));
    prot_open = 1'b0;
    wr(1'b0, cc_word(1'b0, 3, 0));
    wr(1'b1, ct_word(1'b0, 1'b1, 4'h1));
    rd(1'b0, rv); check("R2 cfg protected", rv, cc_word(1'b1, 0, 3));
    rd(1'b1, rv); check("R2 ctl protected", rv, 16'h040A);
    prot_open = 1'b1;

    // R3 reserved bits and write-only restart
    wr(1'b0, 16'hFFFF);
    rd(1'b0, rv); check("R3 cfg readback", rv, 16'h003D);
    wr(1'b1, 16'hFFFF);
    rd(1'b1, rv); check("R3 ctl readback", rv, 16'h040F);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule